// File: doc/BRIEF.md
# Single-Bit Logic Engine with Salvage Register

This block runs one-bit logic instructions against a store of 2048 Boolean variables. The variables sit in the low 16 bits of the first 128 words of a shared working memory that is 24 bits wide. The block keeps a one-bit accumulator and a four-slot salvage register. Each instruction gives either a bit address or a salvage-slot number. An 11-bit bit address is split into a word index (bits 10:4) and a bit position inside that word (bits 3:0).

Instructions that name a memory bit use a single word-wide port to the memory, which has a synchronous read. A store changes only the addressed bit, so it reads the word, merges the new bit in and writes the word back. Instructions on salvage slots and the complement never touch memory and finish in the cycle they are accepted. The `busy` output marks when the block cannot take an instruction. Every LOAD first saves the old accumulator into salvage slot 0 and pushes the other slots up by one. The saved values can later be used as the second operand of AND or OR, but they can never be loaded or stored.

Top module: `bool_bit_engine`

## Requirements
- R1: After reset `acc` is 0, all `salvage` bits are 0, `busy` is 0 and `mem_req` is 0.
- R2: Opcode 0 (LOAD) on bit address A reads memory word A[10:4] and places bit A[3:0] of that word in `acc`. It issues exactly one memory request, a read.
- R3: Every LOAD moves the old `acc` into salvage slot 0 and shifts slots 0..2 into 1..3. The old slot 3 value is lost.
- R4: Opcodes 2 (AND) and 3 (OR) combine `acc` with the addressed memory bit and write the result to `acc`. Each uses one read request.
- R5: Opcodes 4 (AND with slot) and 5 (OR with slot) combine `acc` with the salvage slot chosen by `instr_addr[1:0]`. They make no memory request, and `busy` stays 0.
- R6: Opcode 1 (STORE) writes `acc` into the addressed bit. It reads the word once and writes it once. All other 23 bits of that word, and every other word, stay unchanged.
- R7: Opcode 6 (COMPLEMENT) inverts `acc` in the cycle it is accepted and makes no memory request.
- R8: Only LOAD changes the salvage register. STORE, AND, OR and COMPLEMENT leave it unchanged, and STORE also leaves `acc` unchanged.
- R9: Opcode 7 is reserved. It changes neither `acc` nor `salvage` and makes no memory request.
- R10: An instruction offered while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered; taken when `busy` is 0 |
| instr_op | input | 3 | Opcode |
| instr_addr | input | 11 | Bit address, or slot number in bits 1:0 |
| busy | output | 1 | A memory instruction is in progress |
| acc | output | 1 | Accumulator |
| salvage | output | 4 | Salvage slots, bit i is slot i |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 11 | Word address |
| mem_wdata | output | 24 | Write data |
| mem_rdata | input | 24 | Read data, valid the cycle after a read request |

## Verification
The case that is hardest to reach is the loss of the oldest salvage value. It only happens after five LOADs in a row, each with a different previous accumulator, and it shows up only through the slot-operand instructions. The stimulus loads a chosen pattern of memory bits, so the salvage contents are known. It then uses AND and OR on each slot, and a fifth load, to show which values survive. Stores are aimed at the first and last bit of a 16-bit field in words whose upper 8 bits are non-zero. This shows that the read-modify-write keeps the bits outside the Boolean field.

// File: rtl/bool_bit_engine.sv
module bool_bit_engine #(
  parameter int BITS   = 2048,
  parameter int FIELD  = 16,
  parameter int DATA_W = 24,
  parameter int MEM_AW = 11,
  parameter int SLOTS  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          instr_valid,
  input  logic [2:0]                    instr_op,
  input  logic [$clog2(BITS)-1:0]       instr_addr,
  output logic                          busy,
  output logic                          acc,
  output logic [SLOTS-1:0]              salvage,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [MEM_AW-1:0]             mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic [DATA_W-1:0]             mem_rdata
);
  localparam int BIT_AW = $clog2(BITS);
  localparam int POS_W  = $clog2(FIELD);
  localparam int SEL_W  = $clog2(SLOTS);

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_ANDM  = 3'd2;
  localparam logic [2:0] OP_ORM   = 3'd3;
  localparam logic [2:0] OP_ANDS  = 3'd4;
  localparam logic [2:0] OP_ORS   = 3'd5;
  localparam logic [2:0] OP_COMP  = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_EX, S_WR} state_t;

  state_t              state;
  logic [2:0]          op_q;
  logic [BIT_AW-1:0]   addr_q;
  logic [SLOTS-1:0]    salv_q;
  logic [DATA_W-1:0]   wdata_q, merged;
  logic                acc_q;

  wire                 take = instr_valid && state == S_IDLE;
  wire [POS_W-1:0]     pos  = addr_q[POS_W-1:0];
  wire                 rbit = mem_rdata[pos];
  wire                 sbit = salv_q[instr_addr[SEL_W-1:0]];

  assign busy      = state != S_IDLE;
  assign acc       = acc_q;
  assign salvage   = salv_q;
  assign mem_req   = state == S_RD || state == S_WR;
  assign mem_we    = state == S_WR;
  assign mem_addr  = MEM_AW'(addr_q[BIT_AW-1:POS_W]);
  assign mem_wdata = wdata_q;

  always_comb begin
    merged      = mem_rdata;
    merged[pos] = acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      salv_q  <= '0;
      wdata_q <= '0;
      acc_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          case (instr_op)
            OP_LOAD, OP_STORE, OP_ANDM, OP_ORM: begin
              op_q   <= instr_op;
              addr_q <= instr_addr;
              state  <= S_RD;
            end
            OP_ANDS: acc_q <= acc_q & sbit;
            OP_ORS:  acc_q <= acc_q | sbit;
            OP_COMP: acc_q <= ~acc_q;
            default: ;
          endcase
        end
        S_RD: state <= S_EX;
        S_EX: begin
          state <= S_IDLE;
          case (op_q)
            OP_LOAD: begin
              acc_q  <= rbit;
              salv_q <= {salv_q[SLOTS-2:0], acc_q};
            end
            OP_ANDM: acc_q <= acc_q & rbit;
            OP_ORM:  acc_q <= acc_q | rbit;
            OP_STORE: begin
              wdata_q <= merged;
              state   <= S_WR;
            end
            default: ;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module bool_bit_engine_chk #(
  parameter int DATA_W = 24,
  parameter int MEM_AW = 11,
  parameter int SLOTS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [2:0]        instr_op,
  input logic              busy,
  input logic              acc,
  input logic [SLOTS-1:0]  salvage,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);
  wire take = instr_valid && !busy;

  a_r1_write_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  a_r3_load_push: assert property (@(posedge clk) disable iff (!rst_n)
    (take && instr_op == 3'd0) |=> ##2
      (salvage[0] == $past(acc, 3) && salvage[SLOTS-1:1] == $past(salvage[SLOTS-2:0], 3)));

  a_r5_slot_op_local: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (instr_op == 3'd4 || instr_op == 3'd5)) |=> (!busy && !mem_req && $stable(salvage)));

  a_r6_store_rmw: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($past(mem_req, 2) && !$past(mem_we, 2) &&
      $past(mem_addr, 2) == mem_addr && $countones(mem_wdata ^ $past(mem_rdata)) <= 1));

  a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (take && instr_op == 3'd6) |=> (acc != $past(acc) && $stable(salvage) && !mem_req));

  a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (take && instr_op == 3'd7) |=> ($stable(acc) && $stable(salvage) && !busy));
endmodule

bind bool_bit_engine bool_bit_engine_chk #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .SLOTS(SLOTS)) u_chk (.*);

// File: tb/bool_bit_engine_bench.sv
module bool_bit_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [2:0]  instr_op = 3'd0;
  logic [10:0] instr_addr = '0;
  logic        busy, acc, mem_req, mem_we;
  logic [3:0]  salvage;
  logic [10:0] mem_addr;
  logic [23:0] mem_wdata;
  logic [23:0] mem_rdata = '0;

  logic [23:0] mem   [128];
  logic [23:0] model [128];
  logic        exp_acc = 1'b0;
  logic [3:0]  exp_salv = '0;
  int          checks = 0, failures = 0, reqs = 0, writes = 0;
  logic [10:0] last_addr = '0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bool_bit_engine u_bool_bit_engine (.*);

  always @(posedge clk) begin
    if (mem_req) begin
      reqs <= reqs + 1;
      last_addr <= mem_addr;
      if (mem_we) begin
        mem[mem_addr[6:0]] <= mem_wdata;
        writes <= writes + 1;
      end else mem_rdata <= mem[mem_addr[6:0]];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic state_chk(input string tag);
    chk(acc == exp_acc, {tag, " acc"}, acc, exp_acc);
    chk(salvage == exp_salv, {tag, " salvage"}, salvage, exp_salv);
  endtask

  task automatic issue(input logic [2:0] op, input logic [10:0] a);
    @(negedge clk);
    instr_valid = 1'b1; instr_op = op; instr_addr = a;
    @(negedge clk);
    instr_valid = 1'b0;
    while (busy) @(negedge clk);
    case (op)
      3'd0: begin exp_salv = {exp_salv[2:0], exp_acc}; exp_acc = model[a[10:4]][a[3:0]]; end
      3'd1: model[a[10:4]][a[3:0]] = exp_acc;
      3'd2: exp_acc = exp_acc & model[a[10:4]][a[3:0]];
      3'd3: exp_acc = exp_acc | model[a[10:4]][a[3:0]];
      3'd4: exp_acc = exp_acc & exp_salv[a[1:0]];
      3'd5: exp_acc = exp_acc | exp_salv[a[1:0]];
      3'd6: exp_acc = ~exp_acc;
      default: ;
    endcase
  endtask

  task automatic t_reset;
    chk(acc == 1'b0, "R1 acc", acc, 0);
    chk(salvage == 4'h0, "R1 salvage", salvage, 0);
    chk(!busy && !mem_req, "R1 idle", {busy, mem_req}, 0);
  endtask

  task automatic t_load_map;
    logic [10:0] addrs [5] = '{11'd0, 11'd15, 11'd16, 11'd1000, 11'd2047};
    foreach (addrs[i]) begin
      int r0 = reqs;
      issue(3'd0, addrs[i]);
      state_chk("R2 load");
      chk(last_addr == {4'd0, addrs[i][10:4]}, "R2 word addr", last_addr, addrs[i][10:4]);
      chk(reqs - r0 == 1, "R2 one read", reqs - r0, 1);
    end
  endtask

  task automatic t_salvage_push;
    model[5] = 24'h00_0000; mem[5] = 24'h00_0000;
    model[5][15:0] = 16'b0000_0000_0001_0110; mem[5] = model[5];
    for (int k = 0; k < 6; k++) begin
      issue(3'd0, {4'd5, 4'(k), 3'd0} >> 3 << 0);
      state_chk("R3 push");
    end
    for (int s = 0; s < 4; s++) begin
      issue(3'd6, '0);
      issue(3'd5, 11'(s));
      state_chk("R5 or slot");
      issue(3'd4, 11'(s));
      state_chk("R5 and slot");
    end
  endtask

  task automatic t_mem_logic;
    for (int k = 0; k < 8; k++) begin
      issue(3'(2 + (k % 2)), 11'(k * 97 + 3));
      state_chk("R4 mem logic / R8 salvage kept");
    end
  endtask

  task automatic t_slot_local;
    int r0 = reqs;
    @(negedge clk);
    instr_valid = 1'b1; instr_op = 3'd5; instr_addr = 11'd2;
    @(negedge clk);
    instr_valid = 1'b0;
    exp_acc = exp_acc | exp_salv[2];
    chk(!busy, "R5 no busy", busy, 0);
    chk(reqs == r0, "R5 no request", reqs - r0, 0);
    state_chk("R5 slot result");
  endtask

  task automatic t_store;
    logic [10:0] addrs [4] = '{11'd32, 11'd47, 11'd2032, 11'd2047};
    foreach (addrs[i]) begin
      int r0 = reqs, w0 = writes;
      issue(3'd6, '0);
      issue(3'd1, addrs[i]);
      chk(mem[addrs[i][10:4]] == model[addrs[i][10:4]], "R6 word", mem[addrs[i][10:4]], model[addrs[i][10:4]]);
      chk(reqs - r0 == 2 && writes - w0 == 1, "R6 read+write", reqs - r0, 2);
      state_chk("R8 store keeps state");
    end
    for (int w = 0; w < 128; w++)
      if (mem[w] != model[w]) chk(1'b0, "R6 other words", mem[w], model[w]);
    checks++;
  endtask

  task automatic t_comp_reserved;
    int r0 = reqs;
    issue(3'd6, 11'd5);
    state_chk("R7 complement");
    issue(3'd6, 11'd5);
    state_chk("R7 complement twice");
    issue(3'd7, 11'd100);
    state_chk("R9 reserved");
    chk(reqs == r0, "R7 R9 no memory", reqs - r0, 0);
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    instr_valid = 1'b1; instr_op = 3'd0; instr_addr = 11'd48;
    @(negedge clk);
    instr_op = 3'd6; instr_addr = '0;
    @(negedge clk);
    instr_valid = 1'b0;
    while (busy) @(negedge clk);
    exp_salv = {exp_salv[2:0], exp_acc};
    exp_acc = model[3][0];
    state_chk("R10 ignored while busy");
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int w = 0; w < 128; w++) begin
      mem[w] = {8'hA5 ^ 8'(w), 16'(w * 16'h3C5B) ^ 16'h9E37};
      model[w] = mem[w];
    end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_load_map;
    t_salvage_push;
    t_mem_logic;
    t_slot_local;
    t_store;
    t_comp_reserved;
    t_busy_ignore;
    finish_up;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up;
  end
endmodule